// File: doc/BRIEF.md
# Programmable DRAM Address Bit Mapper

This block translates between DRAM coordinates and a flat 64-bit physical address. The coordinates are 18 row bits, 10 column bits, 2 bank bits, 2 bank-group bits, 1 channel bit, 2 rank bits and 3 logical-rank bits. Each of these 38 bits has its own programmable 6-bit destination position in the physical address. It does not use a fixed concatenation of fields, so any interleaving scheme a memory controller uses can be described bit by bit.

The positions are loaded through a simple 32-bit write port that selects one of eight configuration words. A forward request (a coordinate tuple plus a strobe) returns the scattered physical address one cycle later. A reverse request (a physical address plus a strobe) returns the gathered coordinates one cycle later. Both directions share the same position table and can be issued in the same cycle. Error-reporting logic uses the forward direction to turn a logged DRAM location into an address. Fault-injection logic uses the reverse direction to turn a target address into a location to match.

Top module: `addrmap_xlate`

## Requirements
- R1: A write with `cfg_we`=1 stores `cfg_wdata` into word `cfg_sel` at the next clock edge. Every position field is 6 bits wide; field k of a word occupies bits 6k+5:6k. The fields are assigned as follows:
  - Words 0, 1 and 2 hold row positions 0-14, five per word in ascending order.
  - Word 3 holds row positions 15-17 in fields 0-2 and column position 0 in field 4.
  - Word 4 holds column positions 1-5.
  - Word 5 holds column positions 6-9 in fields 0-3 and bank position 0 in field 4.
  - Word 6 holds bank position 1, group positions 0 and 1, and the channel position in fields 0-3.
  - Word 7 holds rank positions 0 and 1 in fields 0-1 and logical-rank positions 0-2 in fields 2-4.
- R2: For a forward request, `phys_addr` bit p is 1 exactly when some coordinate bit i is 1 and its configured position equals p.
- R3: Coordinate bits that share a position are ORed together. A forward result never has more ones than the request had coordinate ones.
- R4: For a reverse request, each output coordinate bit i equals `rev_addr` bit position[i]. In particular, an all-zero address gives all-zero coordinates.
- R5: `phys_valid` is 1 in exactly the cycle after `fwd_valid` was 1. `coord_valid` is 1 in exactly the cycle after `rev_valid` was 1.
- R6: When no request arrives in a direction, that direction's result outputs keep their previous values.
- R7: Reset clears both valid outputs, both result outputs and every position. After reset, every coordinate bit therefore maps to physical bit 0.
- R8: Some configuration bits have no effect on either direction: bits 31:30 of every word, bits 23:18 of word 3, and bits 29:24 of word 6.
- R9: A request presented in the same cycle as a configuration write is translated with the positions in force before that write.
- R10: Forward and reverse requests in the same cycle are both served independently in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select (0-7) |
| cfg_wdata | input | 32 | Configuration word data |
| fwd_valid | input | 1 | Forward request strobe |
| fwd_row | input | 18 | Row coordinate |
| fwd_col | input | 10 | Column coordinate |
| fwd_bank | input | 2 | Bank coordinate |
| fwd_grp | input | 2 | Bank-group coordinate |
| fwd_chan | input | 1 | Channel coordinate |
| fwd_rank | input | 2 | Rank coordinate |
| fwd_lrank | input | 3 | Logical-rank coordinate |
| rev_valid | input | 1 | Reverse request strobe |
| rev_addr | input | 64 | Physical address to gather from |
| phys_valid | output | 1 | Forward result valid |
| phys_addr | output | 64 | Forward result address |
| coord_valid | output | 1 | Reverse result valid |
| rv_row | output | 18 | Gathered row |
| rv_col | output | 10 | Gathered column |
| rv_bank | output | 2 | Gathered bank |
| rv_grp | output | 2 | Gathered bank group |
| rv_chan | output | 1 | Gathered channel |
| rv_rank | output | 2 | Gathered rank |
| rv_lrank | output | 3 | Gathered logical rank |

## Verification
A position field decoded from the wrong word bits, or a stale position register, shows up on the first forward request that sets that coordinate bit. The request's single one lands at a different `phys_addr` bit, one cycle after the strobe. The single-bit walk over all 38 coordinate bits exposes any such slip, including a field shifted into a neighbour's slot. A broken output stage shows up one cycle after the stimulus: the valid flag is wrong, or the result is not held between requests. A gather that picks the wrong address bit shows up as a failed round trip through reverse and forward on the next result.

// File: rtl/addrmap_pkg.sv
package addrmap_pkg;
    // Coordinate widths
    parameter int ROW_BITS   = 18;
    parameter int COL_BITS   = 10;
    parameter int BANK_BITS  = 2;
    parameter int GRP_BITS   = 2;
    parameter int CHAN_BITS  = 1;
    parameter int RANK_BITS  = 2;
    parameter int LRANK_BITS = 3;

    // Configuration word layout
    parameter int REG_W          = 32;
    parameter int FIELD_W        = 6;
    parameter int FIELDS_PER_REG = 5;

    // Offsets in the flattened coordinate vector (row at the bottom)
    localparam int COL_LO   = ROW_BITS;
    localparam int BANK_LO  = COL_LO + COL_BITS;
    localparam int GRP_LO   = BANK_LO + BANK_BITS;
    localparam int CHAN_LO  = GRP_LO + GRP_BITS;
    localparam int RANK_LO  = CHAN_LO + CHAN_BITS;
    localparam int LRANK_LO = RANK_LO + RANK_BITS;
    localparam int COORD_BITS = LRANK_LO + LRANK_BITS;

    // Two spare slots: one before column 0, one before rank 0
    localparam int SLOT_COUNT = COORD_BITS + 2;
    localparam int NUM_REGS   = (SLOT_COUNT + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
    localparam int SEL_W      = $clog2(NUM_REGS);

    // Field slot (word * FIELDS_PER_REG + field) holding flat coordinate bit j
    function automatic int slot_of(input int j);
        if (j < ROW_BITS)
            return j;
        else if (j < RANK_LO)
            return j + 1;
        else
            return j + 2;
    endfunction
endpackage

// File: rtl/addrmap_cfg.sv
module addrmap_cfg
    import addrmap_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [SEL_W-1:0]            cfg_sel,
    input  logic [REG_W-1:0]            cfg_wdata,
    output logic [COORD_BITS*POS_W-1:0] pos_flat
);
    // Reserved and spare bits are accepted on the bus but never stored
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata;

    for (genvar j = 0; j < COORD_BITS; j++) begin : g_pos
        localparam int SLOT = slot_of(j);
        localparam int WORD = SLOT / FIELDS_PER_REG;
        localparam int LSB  = (SLOT % FIELDS_PER_REG) * FIELD_W;

        logic [POS_W-1:0] pos_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pos_q <= '0;
            else if (cfg_we && cfg_sel == SEL_W'(WORD))
                pos_q <= cfg_wdata[LSB +: POS_W];
        end

        assign pos_flat[j*POS_W +: POS_W] = pos_q;
    end
endmodule

// File: rtl/addrmap_scatter.sv
module addrmap_scatter
    import addrmap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int POS_W  = 6
) (
    input  logic [COORD_BITS-1:0]       coord,
    input  logic [COORD_BITS*POS_W-1:0] pos_flat,
    output logic [ADDR_W-1:0]           addr
);
    always_comb begin
        addr = '0;
        for (int j = 0; j < COORD_BITS; j++) begin
            if (coord[j])
                addr[pos_flat[j*POS_W +: POS_W]] = 1'b1;
        end
    end
endmodule

// File: rtl/addrmap_gather.sv
module addrmap_gather
    import addrmap_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int POS_W  = 6
) (
    input  logic [ADDR_W-1:0]           addr,
    input  logic [COORD_BITS*POS_W-1:0] pos_flat,
    output logic [COORD_BITS-1:0]       coord
);
    for (genvar j = 0; j < COORD_BITS; j++) begin : g_pick
        assign coord[j] = addr[pos_flat[j*POS_W +: POS_W]];
    end
endmodule

// File: rtl/addrmap_xlate.sv
module addrmap_xlate
    import addrmap_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [REG_W-1:0]      cfg_wdata,
    input  logic                  fwd_valid,
    input  logic [ROW_BITS-1:0]   fwd_row,
    input  logic [COL_BITS-1:0]   fwd_col,
    input  logic [BANK_BITS-1:0]  fwd_bank,
    input  logic [GRP_BITS-1:0]   fwd_grp,
    input  logic [CHAN_BITS-1:0]  fwd_chan,
    input  logic [RANK_BITS-1:0]  fwd_rank,
    input  logic [LRANK_BITS-1:0] fwd_lrank,
    input  logic                  rev_valid,
    input  logic [ADDR_W-1:0]     rev_addr,
    output logic                  phys_valid,
    output logic [ADDR_W-1:0]     phys_addr,
    output logic                  coord_valid,
    output logic [ROW_BITS-1:0]   rv_row,
    output logic [COL_BITS-1:0]   rv_col,
    output logic [BANK_BITS-1:0]  rv_bank,
    output logic [GRP_BITS-1:0]   rv_grp,
    output logic [CHAN_BITS-1:0]  rv_chan,
    output logic [RANK_BITS-1:0]  rv_rank,
    output logic [LRANK_BITS-1:0] rv_lrank
);
    localparam int POS_W = $clog2(ADDR_W);

    logic [COORD_BITS*POS_W-1:0] pos_flat;
    logic [COORD_BITS-1:0]       fwd_flat;
    logic [ADDR_W-1:0]           scat_addr;
    logic [COORD_BITS-1:0]       gath_coord;

    logic                  phys_valid_q;
    logic [ADDR_W-1:0]     phys_q;
    logic                  coord_valid_q;
    logic [COORD_BITS-1:0] coord_q;

    assign fwd_flat = {fwd_lrank, fwd_rank, fwd_chan, fwd_grp, fwd_bank, fwd_col, fwd_row};

    addrmap_cfg #(.POS_W(POS_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pos_flat  (pos_flat)
    );

    addrmap_scatter #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_scatter (
        .coord    (fwd_flat),
        .pos_flat (pos_flat),
        .addr     (scat_addr)
    );

    addrmap_gather #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_gather (
        .addr     (rev_addr),
        .pos_flat (pos_flat),
        .coord    (gath_coord)
    );

    // Result register: each direction captures only on its own strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phys_valid_q  <= 1'b0;
            phys_q        <= '0;
            coord_valid_q <= 1'b0;
            coord_q       <= '0;
        end else begin
            phys_valid_q  <= fwd_valid;
            coord_valid_q <= rev_valid;
            if (fwd_valid)
                phys_q <= scat_addr;
            if (rev_valid)
                coord_q <= gath_coord;
        end
    end

    // Output drive
    assign phys_valid  = phys_valid_q;
    assign phys_addr   = phys_q;
    assign coord_valid = coord_valid_q;
    assign rv_row      = coord_q[0 +: ROW_BITS];
    assign rv_col      = coord_q[COL_LO +: COL_BITS];
    assign rv_bank     = coord_q[BANK_LO +: BANK_BITS];
    assign rv_grp      = coord_q[GRP_LO +: GRP_BITS];
    assign rv_chan     = coord_q[CHAN_LO +: CHAN_BITS];
    assign rv_rank     = coord_q[RANK_LO +: RANK_BITS];
    assign rv_lrank    = coord_q[LRANK_LO +: LRANK_BITS];

    // R5
    fwd_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> phys_valid);
    // R5
    fwd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |=> !phys_valid);
    // R5
    rev_valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rev_valid |=> coord_valid);
    // R5
    rev_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_valid |=> !coord_valid);
    // R6
    fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |=> $stable(phys_addr));
    // R6
    rev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_valid |=> ($stable(rv_row) && $stable(rv_col) && $stable(rv_lrank)));
    // R3
    fwd_ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> ($countones(phys_addr) <= $past($countones(fwd_flat))));
    // R4
    rev_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_valid && rev_addr == '0) |=>
            (rv_row == '0 && rv_col == '0 && rv_bank == '0 && rv_grp == '0
             && rv_chan == '0 && rv_rank == '0 && rv_lrank == '0));
endmodule

// File: tb/sim_addrmap_xlate.sv
module sim_addrmap_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 38;

    // Stimulus vectors, flat order {lrank, rank, chan, grp, bank, col, row}
    localparam logic [NC-1:0] STIM [8] = '{
        38'h00_0000_0000, 38'h00_0000_0001, 38'h2A_AAAA_AAAA, 38'h15_5555_5555,
        38'h3F_FFFF_FFFF, 38'h00_0003_FFFF, 38'h20_0000_0000, 38'h3C_0F0F_F0F0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        fwd_valid = 1'b0;
    logic [17:0] fwd_row = '0;
    logic [9:0]  fwd_col = '0;
    logic [1:0]  fwd_bank = '0;
    logic [1:0]  fwd_grp = '0;
    logic [0:0]  fwd_chan = '0;
    logic [1:0]  fwd_rank = '0;
    logic [2:0]  fwd_lrank = '0;
    logic        rev_valid = 1'b0;
    logic [63:0] rev_addr = '0;
    logic        phys_valid;
    logic [63:0] phys_addr;
    logic        coord_valid;
    logic [17:0] rv_row;
    logic [9:0]  rv_col;
    logic [1:0]  rv_bank;
    logic [1:0]  rv_grp;
    logic [0:0]  rv_chan;
    logic [1:0]  rv_rank;
    logic [2:0]  rv_lrank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int tb_pos [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    addrmap_xlate u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .fwd_valid(fwd_valid), .fwd_row(fwd_row), .fwd_col(fwd_col), .fwd_bank(fwd_bank),
        .fwd_grp(fwd_grp), .fwd_chan(fwd_chan), .fwd_rank(fwd_rank), .fwd_lrank(fwd_lrank),
        .rev_valid(rev_valid), .rev_addr(rev_addr), .phys_valid(phys_valid), .phys_addr(phys_addr),
        .coord_valid(coord_valid), .rv_row(rv_row), .rv_col(rv_col), .rv_bank(rv_bank),
        .rv_grp(rv_grp), .rv_chan(rv_chan), .rv_rank(rv_rank), .rv_lrank(rv_lrank)
    );

    function automatic logic [63:0] model_fwd(input logic [NC-1:0] c);
        logic [63:0] r;
        r = '0;
        for (int j = 0; j < NC; j++)
            if (c[j]) r[tb_pos[j]] = 1'b1;
        return r;
    endfunction

    function automatic logic [NC-1:0] model_rev(input logic [63:0] a);
        logic [NC-1:0] r;
        for (int j = 0; j < NC; j++)
            r[j] = a[tb_pos[j]];
        return r;
    endfunction

    // Word layout of R1; spare fills the bits R8 says are ignored
    function automatic logic [31:0] cfg_word(input int w, input bit spare);
        logic [31:0] v;
        int s;
        v = '0;
        for (int j = 0; j < NC; j++) begin
            s = (j < 18) ? j : ((j < 33) ? j + 1 : j + 2);
            if (s / 5 == w) v[(s % 5) * 6 +: 6] = 6'(tb_pos[j]);
        end
        if (spare) begin
            v[31:30] = 2'b11;
            if (w == 3) v[23:18] = 6'h3F;
            if (w == 6) v[29:24] = 6'h3F;
        end
        return v;
    endfunction

    function automatic logic [NC-1:0] got_coord();
        return {rv_lrank, rv_rank, rv_chan, rv_grp, rv_bank, rv_col, rv_row};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic drive_fwd(input logic [NC-1:0] c);
        fwd_row = c[17:0]; fwd_col = c[27:18]; fwd_bank = c[29:28]; fwd_grp = c[31:30];
        fwd_chan = c[32]; fwd_rank = c[34:33]; fwd_lrank = c[37:35];
    endtask

    task automatic load_cfg(input bit spare);
        for (int w = 0; w < 8; w++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_sel = 3'(w); cfg_wdata = cfg_word(w, spare);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue both directions in one cycle; results are due at the next falling edge
    task automatic run_req(input bit fv, input logic [NC-1:0] c, input bit rv, input logic [63:0] a);
        @(negedge clk);
        drive_fwd(c); fwd_valid = fv; rev_addr = a; rev_valid = rv;
        @(negedge clk);
        fwd_valid = 1'b0; rev_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R5 watchdog expired got 0 exp 1");
            finish_run();
        end
    end

    initial begin
        logic [63:0] held;
        logic [NC-1:0] held_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 phys_valid after reset", 64'(phys_valid), 64'd0);
        check("R7 coord_valid after reset", 64'(coord_valid), 64'd0);
        check("R7 phys_addr after reset", phys_addr, 64'd0);
        check("R7 coords after reset", 64'(got_coord()), 64'd0);
        // R7 all positions zero: everything lands on bit 0
        run_req(1'b1, 38'h15_5555_5555, 1'b1, 64'h1);
        check("R7 zero positions forward", phys_addr, 64'h1);
        check("R7 zero positions reverse", 64'(got_coord()), 64'(38'h3F_FFFF_FFFF));
        run_req(1'b0, '0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        check("R7 zero positions reverse bit0 clear", 64'(got_coord()), 64'd0);

        // Distinct positions
        for (int j = 0; j < NC; j++) tb_pos[j] = (j * 5 + 3) % 64;
        load_cfg(1'b0);

        // R1 walk every coordinate bit to its own field
        for (int j = 0; j < NC; j++) begin
            run_req(1'b1, NC'(1) << j, 1'b0, '0);
            check($sformatf("R1 walk bit %0d", j), phys_addr, 64'(1) << tb_pos[j]);
        end

        // Table walk: R2 forward, R4 round trip and R4 arbitrary gather
        for (int i = 0; i < 8; i++) begin
            run_req(1'b1, STIM[i], 1'b1, 64'hDEAD_BEEF_0123_4567 ^ 64'(STIM[i]));
            check($sformatf("R2 forward vec %0d", i), phys_addr, model_fwd(STIM[i]));
            check($sformatf("R4 gather vec %0d", i), 64'(got_coord()),
                  64'(model_rev(64'hDEAD_BEEF_0123_4567 ^ 64'(STIM[i]))));
            run_req(1'b0, '0, 1'b1, model_fwd(STIM[i]));
            check($sformatf("R4 round trip vec %0d", i), 64'(got_coord()), 64'(STIM[i]));
        end

        // R5 and R6: idle cycle after a request
        run_req(1'b1, STIM[2], 1'b1, 64'h0F0F_0000_FFFF_1234);
        check("R5 phys_valid after request", 64'(phys_valid), 64'd1);
        check("R5 coord_valid after request", 64'(coord_valid), 64'd1);
        held = phys_addr;
        held_c = got_coord();
        drive_fwd(STIM[3]); rev_addr = ~rev_addr;
        @(negedge clk);
        check("R5 phys_valid idle", 64'(phys_valid), 64'd0);
        check("R5 coord_valid idle", 64'(coord_valid), 64'd0);
        check("R6 phys_addr held", phys_addr, held);
        check("R6 coords held", 64'(got_coord()), 64'(held_c));

        // R10 simultaneous directions
        run_req(1'b1, STIM[7], 1'b1, 64'h8000_0000_0000_0008);
        check("R10 forward alongside reverse", phys_addr, model_fwd(STIM[7]));
        check("R10 reverse alongside forward", 64'(got_coord()),
              64'(model_rev(64'h8000_0000_0000_0008)));

        // R9 write and request in the same cycle: old row 0 position (3) applies
        tb_pos[0] = 60;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = cfg_word(0, 1'b0);
        drive_fwd(NC'(1)); fwd_valid = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; fwd_valid = 1'b0;
        check("R9 same-cycle write uses old position", phys_addr, 64'(1) << 3);
        run_req(1'b1, NC'(1), 1'b0, '0);
        check("R9 next request uses new position", phys_addr, 64'(1) << 60);

        // R8 reserved and spare bits set: results unchanged
        load_cfg(1'b1);
        run_req(1'b1, STIM[4], 1'b1, 64'h5A5A_A5A5_3C3C_C3C3);
        check("R8 spare bits forward", phys_addr, model_fwd(STIM[4]));
        check("R8 spare bits reverse", 64'(got_coord()), 64'(model_rev(64'h5A5A_A5A5_3C3C_C3C3)));
        run_req(1'b1, NC'(1) << 18, 1'b0, '0);
        check("R8 column 0 beside spare field", phys_addr, 64'(1) << tb_pos[18]);
        run_req(1'b1, NC'(1) << 32, 1'b0, '0);
        check("R8 channel beside spare field", phys_addr, 64'(1) << tb_pos[32]);

        // R3 all bits collide on position 7
        for (int j = 0; j < NC; j++) tb_pos[j] = 7;
        load_cfg(1'b0);
        run_req(1'b1, 38'h3F_FFFF_FFFF, 1'b1, 64'h80);
        check("R3 all ones collide", phys_addr, 64'h80);
        check("R3 shared position gather", 64'(got_coord()), 64'(38'h3F_FFFF_FFFF));
        run_req(1'b1, 38'h0, 1'b1, ~64'h80);
        check("R3 zero coordinates", phys_addr, 64'h0);
        check("R4 shared position clear", 64'(got_coord()), 64'd0);

        finish_run();
    end
endmodule